// File: doc/BRIEF.md
# Real-Time-Clock Register File with Read Snapshot

This block holds the byte-addressed register space of a real-time clock behind a byte-level serial slave. The space is 64 bytes. The lowest seven bytes show the time fields. The next byte is a control register. Everything above it is plain RAM. A protocol engine in front of the block turns bus activity into a few pulses:
- a transaction start, separately for writes and for reads;
- a strobe for each byte written, with its data;
- a strobe for each byte read.

Bit-level bus signalling, address matching and acknowledges stay in that engine.

The block does not read the running clock directly. It reads a frozen copy that is refreshed in two cases: when a read transaction starts, and whenever the byte pointer wraps back to zero. A multi-byte read therefore sees one coherent time. Bytes written to the time addresses are not stored. They leave on a load port that presets the external clock counter. The control register forces three bits to zero. Its oscillator-stop flag is set only by hardware and can be cleared by software, but software cannot set it.

Top module: `rtc_regfile`

## Requirements
- R1: After synchronous reset:
  - the pointer is 0;
  - no address byte is pending;
  - the control byte and the 56 RAM bytes read 0;
  - rd_data shows 0 and load_en is low.
- R2: After a wr_start pulse, the first wr_strobe byte is not stored anywhere. Its low 6 bits become the pointer.
- R3: Every later data byte, written or read, advances the pointer by one after it is accessed. The pointer wraps from 63 to 0.
- R4: A rd_start pulse copies live_time into the seven time bytes. Byte i is live_time[8*i+7:8*i]. Later reads return that copy even if live_time changes.
- R5: When a data access moves the pointer from 63 to 0, live_time is copied into the time bytes again. This applies to a read and to a write.
- R6: A data write to addresses 0 to 6 leaves the time copy unchanged. One cycle later it produces a single load_en pulse with load_idx equal to the address and load_data equal to the byte.
- R7: A write to address 7 stores the byte with bits 2, 3 and 6 forced to 0.
- R8: Control bit 5 is set by an osc_fail pulse. A write with bit 5 at 0 clears it. A write with bit 5 at 1 leaves it unchanged. osc_fail wins over a clearing write in the same cycle.
- R9: Data writes to addresses 8 to 63 store the byte unchanged, and reads return it.
- R10: A wr_start pulse re-arms the address-byte state even in the middle of a write sequence. The next byte is then taken as a new pointer.
- R11: rd_data combinationally shows the byte at the current pointer. It is valid in the same cycle as rd_strobe, and the pointer moves on the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | Pulse: a write transaction begins |
| rd_start | input | 1 | Pulse: a read transaction begins, time copy refreshed |
| wr_strobe | input | 1 | One written byte is present on wr_data |
| wr_data | input | 8 | Written byte |
| rd_strobe | input | 1 | One byte is being read |
| rd_data | output | 8 | Byte at the current pointer |
| live_time | input | 56 | Running clock fields, byte i at bits 8i+7:8i |
| osc_fail | input | 1 | Pulse from the oscillator monitor that sets control bit 5 |
| load_en | output | 1 | Registered pulse: preset one clock field |
| load_idx | output | 3 | Time field index for the preset |
| load_data | output | 8 | Preset value |

## Verification
The hardest situation to reach is the recapture at the pointer wrap. No transaction boundary marks it. It happens only on the access that follows byte 63, and it can be told apart from the rd_start copy only if live_time changes between the two copies. The stimulus first points a write sequence at 62 and stores two bytes, so the write crosses the top, then changes live_time. It then points at 0 and reads without any rd_start, which exposes the copy taken by the write wrap. A second pass reads across 63 after live_time has changed again, so the read-side wrap is exercised too.

// File: rtl/rtc_regfile_pkg.sv
package rtc_regfile_pkg;
  localparam int BYTE_W = 8;
  // control register bits that always read back as zero
  localparam logic [BYTE_W-1:0] CTRL_ZERO_MASK = 8'h4C;
  // oscillator-stop flag: hardware sets, software may only clear
  localparam logic [BYTE_W-1:0] CTRL_FLAG_MASK = 8'h20;
endpackage

// File: rtl/rtc_ptr_ctrl.sv
module rtc_ptr_ctrl #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_start,
  input  logic              rd_start,
  input  logic              wr_strobe,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              rd_strobe,
  output logic [ADDR_W-1:0] ptr,
  output logic              addr_pend,
  output logic              data_wr,
  output logic              wrap_cap
);
  localparam logic [ADDR_W-1:0] PTR_MAX = {ADDR_W{1'b1}};

  logic no_start;
  logic data_acc;

  assign no_start = !wr_start && !rd_start;
  assign data_wr  = no_start && wr_strobe && !addr_pend;
  assign data_acc = data_wr || (no_start && rd_strobe && !wr_strobe);
  assign wrap_cap = data_acc && (ptr == PTR_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      addr_pend <= 1'b0;
    end else if (wr_start) begin
      addr_pend <= 1'b1;
    end else if (no_start && wr_strobe && addr_pend) begin
      ptr       <= addr_in;
      addr_pend <= 1'b0;
    end else if (data_acc) begin
      ptr       <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_time_snap.sv
module rtc_time_snap #(
  parameter int TIME_BYTES = 7,
  parameter int IDX_W      = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    capture,
  input  logic [TIME_BYTES*8-1:0] live_time,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [7:0]              rd_byte
);
  logic [7:0] snap_q [TIME_BYTES];

  generate
    for (genvar i = 0; i < TIME_BYTES; i++) begin : g_field
      always_ff @(posedge clk) begin
        if (rst)          snap_q[i] <= '0;
        else if (capture) snap_q[i] <= live_time[i*8 +: 8];
      end
    end
  endgenerate

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < TIME_BYTES; i++)
      if (rd_idx == IDX_W'(i)) rd_byte = snap_q[i];
  end
endmodule

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
  import rtc_regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [BYTE_W-1:0] din,
  input  logic              osc_fail,
  output logic [BYTE_W-1:0] q
);
  logic [BYTE_W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (we)
      nxt = (din & ~CTRL_ZERO_MASK & ~CTRL_FLAG_MASK) | (din & q & CTRL_FLAG_MASK);
    if (osc_fail)
      nxt = nxt | CTRL_FLAG_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/rtc_user_ram.sv
module rtc_user_ram #(
  parameter int ADDR_W = 6,
  parameter int BASE   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout
);
  localparam int DEPTH = (1 << ADDR_W) - BASE;

  logic [7:0]        mem_q [DEPTH];
  logic [ADDR_W-1:0] off;

  assign off  = addr - ADDR_W'(BASE);
  assign dout = mem_q[off];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[off] <= din;
    end
  end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_regfile_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int TIME_BYTES = 7,
  parameter int IDX_W      = $clog2(TIME_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_start,
  input  logic                    rd_start,
  input  logic                    wr_strobe,
  input  logic [7:0]              wr_data,
  input  logic                    rd_strobe,
  output logic [7:0]              rd_data,
  input  logic [TIME_BYTES*8-1:0] live_time,
  input  logic                    osc_fail,
  output logic                    load_en,
  output logic [IDX_W-1:0]        load_idx,
  output logic [7:0]              load_data
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(TIME_BYTES);
  localparam int                RAM_BASE  = TIME_BYTES + 1;

  logic [ADDR_W-1:0] ptr_q;
  logic              addr_pend_q;
  logic              data_wr;
  logic              wrap_cap;
  logic              in_time;
  logic [7:0]        snap_byte;
  logic [7:0]        ram_byte;
  logic [BYTE_W-1:0] ctrl_q;

  assign in_time = ptr_q < CTRL_ADDR;

  rtc_ptr_ctrl #(.ADDR_W(ADDR_W)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .wr_start  (wr_start),
    .rd_start  (rd_start),
    .wr_strobe (wr_strobe),
    .addr_in   (wr_data[ADDR_W-1:0]),
    .rd_strobe (rd_strobe),
    .ptr       (ptr_q),
    .addr_pend (addr_pend_q),
    .data_wr   (data_wr),
    .wrap_cap  (wrap_cap)
  );

  rtc_time_snap #(.TIME_BYTES(TIME_BYTES), .IDX_W(IDX_W)) u_snap (
    .clk       (clk),
    .rst       (rst),
    .capture   (rd_start || wrap_cap),
    .live_time (live_time),
    .rd_idx    (ptr_q[IDX_W-1:0]),
    .rd_byte   (snap_byte)
  );

  rtc_ctrl_reg u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .we       (data_wr && (ptr_q == CTRL_ADDR)),
    .din      (wr_data),
    .osc_fail (osc_fail),
    .q        (ctrl_q)
  );

  rtc_user_ram #(.ADDR_W(ADDR_W), .BASE(RAM_BASE)) u_ram (
    .clk  (clk),
    .rst  (rst),
    .we   (data_wr && (ptr_q > CTRL_ADDR)),
    .addr (ptr_q),
    .din  (wr_data),
    .dout (ram_byte)
  );

  always_comb begin
    if (in_time)                 rd_data = snap_byte;
    else if (ptr_q == CTRL_ADDR) rd_data = ctrl_q;
    else                         rd_data = ram_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_en   <= 1'b0;
      load_idx  <= '0;
      load_data <= '0;
    end else begin
      load_en <= data_wr && in_time;
      if (data_wr && in_time) begin
        load_idx  <= ptr_q[IDX_W-1:0];
        load_data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk #(
  parameter int ADDR_W     = 6,
  parameter int TIME_BYTES = 7,
  parameter int IDX_W      = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_start,
  input logic              rd_start,
  input logic              wr_strobe,
  input logic              rd_strobe,
  input logic [7:0]        wr_data,
  input logic              osc_fail,
  input logic [ADDR_W-1:0] ptr,
  input logic              addr_pend,
  input logic [7:0]        ctrl_q,
  input logic              load_en,
  input logic [IDX_W-1:0]  load_idx,
  input logic [7:0]        load_data
);
  logic quiet;
  assign quiet = !wr_start && !rd_start;

  // R1
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (ptr == '0 && !addr_pend && ctrl_q == 8'h00 && !load_en));

  // R2
  p_addr_byte_r2: assert property (@(posedge clk) disable iff (rst)
    (quiet && wr_strobe && addr_pend) |=>
      (ptr == $past(wr_data[ADDR_W-1:0]) && !addr_pend));

  // R3
  p_advance_r3: assert property (@(posedge clk) disable iff (rst)
    (quiet && ((wr_strobe && !addr_pend) || (rd_strobe && !wr_strobe))) |=>
      (ptr == ADDR_W'($past(ptr) + 1'b1)));

  // R6
  p_load_fwd_r6: assert property (@(posedge clk) disable iff (rst)
    (quiet && wr_strobe && !addr_pend && ptr < ADDR_W'(TIME_BYTES)) |=>
      (load_en && load_idx == $past(ptr[IDX_W-1:0]) && load_data == $past(wr_data)));

  // R6
  p_load_only_on_write_r6: assert property (@(posedge clk) disable iff (rst)
    load_en |-> $past(wr_strobe));

  // R8
  p_flag_hw_only_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_q[5]) |-> $past(osc_fail));

  // R10
  p_rearm_r10: assert property (@(posedge clk) disable iff (rst)
    wr_start |=> addr_pend);
endmodule

bind rtc_regfile rtc_regfile_chk #(
  .ADDR_W(ADDR_W), .TIME_BYTES(TIME_BYTES), .IDX_W(IDX_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_start  (wr_start),
  .rd_start  (rd_start),
  .wr_strobe (wr_strobe),
  .rd_strobe (rd_strobe),
  .wr_data   (wr_data),
  .osc_fail  (osc_fail),
  .ptr       (ptr_q),
  .addr_pend (addr_pend_q),
  .ctrl_q    (ctrl_q),
  .load_en   (load_en),
  .load_idx  (load_idx),
  .load_data (load_data)
);

// File: tb/tb_rtc_regfile.sv
`timescale 1ns/1ps
module tb_rtc_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_start = 1'b0, rd_start = 1'b0;
  logic        wr_strobe = 1'b0, rd_strobe = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [55:0] live_time = '0;
  logic        osc_fail = 1'b0;
  logic        load_en;
  logic [2:0]  load_idx;
  logic [7:0]  load_data;

  int checks = 0;
  int errors = 0;

  logic [7:0]  rd_exp_q [$];
  string       rd_tag_q [$];
  logic [10:0] ld_exp_q [$];

  always #2.5 clk = ~clk;

  rtc_regfile dut (
    .clk(clk), .rst(rst), .wr_start(wr_start), .rd_start(rd_start),
    .wr_strobe(wr_strobe), .wr_data(wr_data), .rd_strobe(rd_strobe),
    .rd_data(rd_data), .live_time(live_time), .osc_fail(osc_fail),
    .load_en(load_en), .load_idx(load_idx), .load_data(load_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wstart();
    wr_start = 1'b1; step(); wr_start = 1'b0;
  endtask

  task automatic rstart();
    rd_start = 1'b1; step(); rd_start = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] d);
    wr_strobe = 1'b1; wr_data = d; step(); wr_strobe = 1'b0;
  endtask

  task automatic wtime(input logic [2:0] idx, input logic [7:0] d);
    ld_exp_q.push_back({idx, d});
    wbyte(d);
  endtask

  task automatic rbyte(input logic [7:0] exp, input string tag);
    rd_exp_q.push_back(exp);
    rd_tag_q.push_back(tag);
    rd_strobe = 1'b1; step(); rd_strobe = 1'b0;
  endtask

  task automatic seek(input logic [7:0] a);
    wstart(); wbyte(a);
  endtask

  // monitor: read data is compared in the strobe cycle (R11)
  always @(negedge clk) begin
    if (!rst && rd_strobe) begin
      if (rd_exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected read", rd_data, 0);
      end else begin
        automatic logic [7:0] e = rd_exp_q.pop_front();
        automatic string t = rd_tag_q.pop_front();
        check(rd_data === e, t, rd_data, e);
      end
    end
    if (!rst && load_en) begin
      if (ld_exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected load", {load_idx, load_data}, 0);
      end else begin
        automatic logic [10:0] e = ld_exp_q.pop_front();
        check({load_idx, load_data} === e, "R6 load port", {load_idx, load_data}, e);
      end
    end
  end

  localparam logic [55:0] L0 = 56'h01_01_01_01_01_01_17;
  localparam logic [55:0] LA = 56'h24_06_15_03_12_45_30;
  localparam logic [55:0] LB = 56'h99_12_31_07_23_59_59;
  localparam logic [55:0] LC = 56'h11_01_02_01_01_02_03;
  localparam logic [55:0] LD = 56'h33_03_03_03_03_03_33;
  localparam logic [55:0] LE = 56'h22_02_28_05_09_08_07;

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(); step(); rst = 1'b0;
    // R1: reset state at the ports
    #2.5;
    check(rd_data === 8'h00, "R1 rd_data after reset", rd_data, 0);
    check(load_en === 1'b0, "R1 load_en after reset", load_en, 0);
    step();

    // R1/R9: control and RAM cleared; R3/R5 read wrap 63->0 recaptures
    live_time = L0;
    seek(8'd7); rstart();
    rbyte(8'h00, "R1 control cleared");
    for (int a = 8; a < 64; a++) rbyte(8'h00, "R1 RAM cleared");
    rbyte(L0[7:0], "R3 wrap to 0 with fresh copy");

    // R2: address byte not stored
    seek(8'hC9);
    seek(8'h09); rstart();
    rbyte(8'h00, "R2 address byte not stored");

    // R9 store as given, R10 re-arm mid-sequence
    seek(8'd20); wbyte(8'h11);
    wstart(); wbyte(8'd30); wbyte(8'h22);
    seek(8'd20); rstart();
    rbyte(8'h11, "R9 RAM byte 20");
    rbyte(8'h00, "R10 new pointer byte not stored at 21");
    seek(8'd30); rbyte(8'h22, "R10 byte went to new pointer");

    // R4: copy taken at rd_start, stable afterwards
    live_time = LA;
    seek(8'd0); rstart();
    live_time = LB;
    for (int i = 0; i < 7; i++) rbyte(LA[i*8 +: 8], "R4 time copy frozen");

    // R6: time writes go to load port, copy untouched
    seek(8'd1); wtime(3'd1, 8'h59); wtime(3'd2, 8'h23);
    seek(8'd1);
    rbyte(LA[15:8], "R6 copy unchanged by write");
    rbyte(LA[23:16], "R6 copy unchanged by write");

    // R5: write-side wrap recapture
    live_time = LC;
    seek(8'd62); wbyte(8'h77); wbyte(8'h88);
    live_time = LD;
    seek(8'd0);
    rbyte(LC[7:0], "R5 write wrap copy");
    // R5: read-side wrap recapture
    seek(8'd63);
    live_time = LE;
    rbyte(8'h88, "R9 RAM byte 63");
    rbyte(LE[7:0], "R5 read wrap copy byte0");
    rbyte(LE[15:8], "R5 read wrap copy byte1");

    // R7/R8: control register
    seek(8'd7); wbyte(8'hFF);
    seek(8'd7); rbyte(8'h93, "R7 forced zeros, R8 write 1 no set");
    osc_fail = 1'b1; step(); osc_fail = 1'b0;
    seek(8'd7); rbyte(8'hB3, "R8 flag set by osc_fail");
    seek(8'd7); wbyte(8'hFF);
    seek(8'd7); rbyte(8'hB3, "R8 write 1 keeps flag");
    seek(8'd7); wbyte(8'hDF);
    seek(8'd7); rbyte(8'h93, "R8 write 0 clears flag");
    seek(8'd7); osc_fail = 1'b1; wbyte(8'h00); osc_fail = 1'b0;
    seek(8'd7); rbyte(8'h20, "R8 osc_fail beats clearing write");

    step(); step();
    check(rd_exp_q.size() == 0, "R11 reads all observed", rd_exp_q.size(), 0);
    check(ld_exp_q.size() == 0, "R6 loads all observed", ld_exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule